// File: doc/BRIEF.md
# Car Park Pay Station Controller

This block sequences a car park pay station. After reset it shows an "insert ticket" prompt. Once the ticket is inserted it shows a "remove ticket" prompt. Once the ticket is withdrawn it shows the fee still owed, which starts at the full fee. Each accepted coin (worth fifty, twenty or ten cents) lowers the amount owed. When nothing is left to pay, the display shows 0.00 for a short time and the machine returns to the insert prompt.

All four buttons are raw levels sampled by the fast system clock. Each button passes through a two-stage synchroniser and an edge detector, so a press counts once however long it is held. A free counter with a clear input produces a one-cycle enable once per display period. No derived clock is used. Each prompt stays on the display for a minimum number of these periods before the machine moves on.

The display output is four BCD nibbles, one per seven-segment digit. The segment decoding is done outside this block.

Top module: `parking_pay_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the machine in the insert-ticket phase. In that phase `digits` reads 16'hAAAA.
- R2: The phases always run insert-ticket, remove-ticket (`digits` = 16'hBBBB), payment, paid, and then back to insert-ticket.
- R3: The insert and remove phases each last at least PROMPT_TICKS periods of TICK_CYCLES clocks, counted from entry into the phase, before they can advance.
- R4: The insert phase advances only after a rising edge on `btn_ticket`. The remove phase advances only after `btn_ticket` has been seen going from 1 to 0 after that insertion.
- R5: On entry to the payment phase the amount owed is FEE_CENTS. The display shows it as {4'hF, dollars, dimes, cents}, where 4'hF is a blank digit (150 cents gives 16'hF150).
- R6: A coin button held for any number of cycles lowers the amount owed by its value exactly once. The values are 50 for `btn_coin50`, 20 for `btn_coin20` and 10 for `btn_coin10`.
- R7: If coin edges arrive in the same cycle, only one coin is taken, in the priority order fifty, then twenty, then ten.
- R8: A coin that brings the amount to zero or below clamps it to zero and enters the paid phase. The paid phase shows 16'hF000 for PAID_TICKS periods and then returns to the insert prompt.
- R9: Coin presses outside the payment phase are ignored. After such a press the display keeps its prompt, and the later payment still starts at the full fee.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_ticket | input | 1 | Raw ticket-present level |
| btn_coin50 | input | 1 | Raw fifty-cent coin button |
| btn_coin20 | input | 1 | Raw twenty-cent coin button |
| btn_coin10 | input | 1 | Raw ten-cent coin button |
| digits | output | 16 | Four BCD digits, [15:12] leftmost |

## Verification
The bench builds the block with TICK_CYCLES=4, PROMPT_TICKS=2 and PAID_TICKS=2. With these values a display period lasts four clocks instead of fifty million. A whole visit (insert, remove, several coins, paid and back) then takes a few dozen cycles. This puts the minimum-hold boundaries within reach, along with the held-ticket case and the paid timeout. The fee stays at its default of 150, so the clamping and exact-payment cases use the real coin values.

// File: rtl/pkp_pkg.sv
package pkp_pkg;
  localparam int CENT_W = 10;
  typedef logic [CENT_W-1:0] cents_t;

  typedef enum logic [1:0] {
    PH_INSERT = 2'd0,
    PH_REMOVE = 2'd1,
    PH_PAY    = 2'd2,
    PH_PAID   = 2'd3
  } phase_e;

  localparam logic [3:0]  DIG_BLANK   = 4'hF;
  localparam logic [15:0] SHOW_INSERT = 16'hAAAA;
  localparam logic [15:0] SHOW_REMOVE = 16'hBBBB;

  // Subtract a coin from the amount owed; never goes below zero.
  function automatic cents_t sub_clamp(cents_t owed, cents_t coin);
    if (owed <= coin) return '0;
    return owed - coin;
  endfunction

  // Amount owed as a blank digit followed by dollars, dimes and cents.
  function automatic logic [15:0] amount_digits(cents_t c);
    logic [3:0] d_hi, d_mid, d_lo;
    d_hi  = 4'(c / cents_t'(100));
    d_mid = 4'((c / cents_t'(10)) % cents_t'(10));
    d_lo  = 4'(c % cents_t'(10));
    return {DIG_BLANK, d_hi, d_mid, d_lo};
  endfunction
endpackage

// File: rtl/pkp_sync.sv
module pkp_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prv
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= raw[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl[i] = s2;
    assign prv[i] = s3;
  end
endmodule

// File: rtl/pkp_tick_gen.sv
module pkp_tick_gen #(
  parameter int TICK_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST) && !clr;
endmodule

// File: rtl/pkp_display.sv
module pkp_display
  import pkp_pkg::*;
(
  input  phase_e      phase,
  input  cents_t      owed,
  output logic [15:0] digits
);
  always_comb begin
    unique case (phase)
      PH_INSERT: digits = SHOW_INSERT;
      PH_REMOVE: digits = SHOW_REMOVE;
      default:   digits = amount_digits(owed);
    endcase
  end
endmodule

// File: rtl/parking_pay_ctrl.sv
module parking_pay_ctrl
  import pkp_pkg::*;
#(
  parameter int     TICK_CYCLES  = 50_000_000,
  parameter int     PROMPT_TICKS = 2,
  parameter int     PAID_TICKS   = 2,
  parameter cents_t FEE_CENTS    = 10'd150,
  parameter cents_t COIN_HI      = 10'd50,
  parameter cents_t COIN_MID     = 10'd20,
  parameter cents_t COIN_LO      = 10'd10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        btn_ticket,
  input  logic        btn_coin50,
  input  logic        btn_coin20,
  input  logic        btn_coin10,
  output logic [15:0] digits
);
  localparam int NBTN  = 4;
  localparam int HMAX  = (PROMPT_TICKS > PAID_TICKS) ? PROMPT_TICKS : PAID_TICKS;
  localparam int HW    = $clog2(HMAX + 1) + 1;
  localparam logic [HW-1:0] H_PROMPT = HW'(PROMPT_TICKS);
  localparam logic [HW-1:0] H_PAID   = HW'(PAID_TICKS);
  localparam logic [HW-1:0] H_SAT    = HW'(HMAX);
  localparam int B_TK = 0, B_C10 = 1, B_C20 = 2, B_C50 = 3;

  // Synchronised levels and edge pulses
  logic [NBTN-1:0] lvl, prv, rise_v;
  logic            tk_fall;

  pkp_sync #(.N(NBTN)) u_sync (
    .clk (clk),
    .rst (rst),
    .raw ({btn_coin50, btn_coin20, btn_coin10, btn_ticket}),
    .lvl (lvl),
    .prv (prv)
  );

  assign rise_v  = lvl & ~prv;
  assign tk_fall = ~lvl[B_TK] & prv[B_TK];

  // Phase state
  phase_e          phase, phase_nxt;
  cents_t          owed, owed_nxt;
  logic [HW-1:0]   hold_cnt;
  logic            tk_in, tk_out;

  // Named internal events
  logic   tick;
  logic   phase_change;
  logic   prompt_done;
  logic   paid_done;
  logic   coin_accept;
  cents_t coin_val;

  assign phase_change = (phase_nxt != phase);
  assign prompt_done  = (hold_cnt >= H_PROMPT);
  assign paid_done    = (hold_cnt >= H_PAID);
  assign coin_accept  = (phase == PH_PAY) &&
                        (rise_v[B_C50] || rise_v[B_C20] || rise_v[B_C10]);

  always_comb begin
    if (rise_v[B_C50])      coin_val = COIN_HI;
    else if (rise_v[B_C20]) coin_val = COIN_MID;
    else                    coin_val = COIN_LO;
  end

  pkp_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (phase_change),
    .tick (tick)
  );

  // Next-phase logic
  always_comb begin
    phase_nxt = phase;
    owed_nxt  = owed;
    unique case (phase)
      PH_INSERT: begin
        if ((tk_in || rise_v[B_TK]) && prompt_done) phase_nxt = PH_REMOVE;
      end
      PH_REMOVE: begin
        if ((tk_out || tk_fall) && prompt_done) begin
          phase_nxt = PH_PAY;
          owed_nxt  = FEE_CENTS;
        end
      end
      PH_PAY: begin
        if (coin_accept) begin
          owed_nxt = sub_clamp(owed, coin_val);
          if (owed <= coin_val) phase_nxt = PH_PAID;
        end
      end
      PH_PAID: begin
        if (paid_done) phase_nxt = PH_INSERT;
      end
      default: phase_nxt = PH_INSERT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_INSERT;
      owed  <= '0;
    end else begin
      phase <= phase_nxt;
      owed  <= owed_nxt;
    end
  end

  // Ticks spent in the current phase, saturating
  always_ff @(posedge clk) begin
    if (rst || phase_change)       hold_cnt <= '0;
    else if (tick && hold_cnt < H_SAT) hold_cnt <= hold_cnt + 1'b1;
  end

  // Ticket insertion and withdrawal flags
  always_ff @(posedge clk) begin
    if (rst) begin
      tk_in  <= 1'b0;
      tk_out <= 1'b0;
    end else begin
      if (phase_change)                                   tk_in <= 1'b0;
      else if (phase == PH_INSERT && rise_v[B_TK])        tk_in <= 1'b1;

      if (phase == PH_PAY || phase == PH_PAID)            tk_out <= 1'b0;
      else if (tk_fall && (phase == PH_REMOVE ||
               (phase == PH_INSERT && (tk_in || rise_v[B_TK])))) tk_out <= 1'b1;
    end
  end

  pkp_display u_disp (
    .phase  (phase),
    .owed   (owed),
    .digits (digits)
  );
endmodule

// File: rtl/parking_pay_ctrl_chk.sv
module parking_pay_ctrl_chk
  import pkp_pkg::*;
#(
  parameter int     TICK_CYCLES  = 4,
  parameter int     PROMPT_TICKS = 2,
  parameter cents_t FEE_CENTS    = 10'd150,
  parameter int     HW           = 3
) (
  input logic          clk,
  input logic          rst,
  input phase_e        phase,
  input cents_t        owed,
  input logic [HW-1:0] hold_cnt,
  input logic          tick,
  input logic          coin_accept,
  input logic [3:0]    rise_v,
  input logic [15:0]   digits
);
  // R1
  reset_prompt_chk: assert property (@(posedge clk)
    rst |=> (digits == SHOW_INSERT));

  // R2
  phase_order_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |->
      (phase == phase_e'($past(phase) + 2'd1)));

  // R3
  prompt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_REMOVE && $past(phase) == PH_INSERT) |->
      ($past(hold_cnt) >= HW'(PROMPT_TICKS)));

  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    (TICK_CYCLES > 1 && tick) |=> !tick);

  // R5
  owed_bound_chk: assert property (@(posedge clk) disable iff (rst)
    owed <= FEE_CENTS);

  // R5
  pay_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PAY) |-> (digits[15:12] == DIG_BLANK));

  // R6
  coin_single_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_v[3] || rise_v[2] || rise_v[1]) |=> !(rise_v[3] || rise_v[2] || rise_v[1]));

  // R6
  coin_lowers_chk: assert property (@(posedge clk) disable iff (rst)
    coin_accept |=> (owed < $past(owed)));

  // R9
  coin_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_INSERT || phase == PH_PAID) |=> $stable(owed));
endmodule

bind parking_pay_ctrl parking_pay_ctrl_chk #(
  .TICK_CYCLES  (TICK_CYCLES),
  .PROMPT_TICKS (PROMPT_TICKS),
  .FEE_CENTS    (FEE_CENTS),
  .HW           (HW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .phase       (phase),
  .owed        (owed),
  .hold_cnt    (hold_cnt),
  .tick        (tick),
  .coin_accept (coin_accept),
  .rise_v      (rise_v),
  .digits      (digits)
);

// File: tb/parking_pay_ctrl_bench.sv
`timescale 1ns/1ps
module parking_pay_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        btn_ticket = 1'b0;
  logic        btn_coin50 = 1'b0;
  logic        btn_coin20 = 1'b0;
  logic        btn_coin10 = 1'b0;
  logic [15:0] digits;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  parking_pay_ctrl #(
    .TICK_CYCLES  (4),
    .PROMPT_TICKS (2),
    .PAID_TICKS   (2)
  ) u_parking_pay_ctrl (
    .clk        (clk),
    .rst        (rst),
    .btn_ticket (btn_ticket),
    .btn_coin50 (btn_coin50),
    .btn_coin20 (btn_coin20),
    .btn_coin10 (btn_coin10),
    .digits     (digits)
  );

  task automatic check(string req, logic [15:0] exp);
    n_tests++;
    if (digits !== exp) begin
      n_fail++;
      $display("FAIL %s: digits=%h expected=%h", req, digits, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    btn_ticket = 0; btn_coin50 = 0; btn_coin20 = 0; btn_coin10 = 0;
    wait_n(3);
    rst = 1'b0;
  endtask

  // mask bits: 3=fifty 2=twenty 1=ten 0=ticket
  task automatic press(logic [3:0] mask, int hold);
    {btn_coin50, btn_coin20, btn_coin10, btn_ticket} = mask;
    wait_n(hold);
    {btn_coin50, btn_coin20, btn_coin10, btn_ticket} = 4'b0000;
    wait_n(4);
  endtask

  task automatic go_to_pay();
    do_reset();
    press(4'b0001, 2);
    wait_n(25);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset prompt", 16'hAAAA);
  endtask

  task automatic t_ignore_coins();
    do_reset();
    press(4'b1000, 5);
    check("R9 coin in insert phase", 16'hAAAA);
    press(4'b0001, 2);
    wait_n(25);
    check("R9 fee intact after ignored coin", 16'hF150);
  endtask

  task automatic t_prompt_hold();
    do_reset();
    btn_ticket = 1'b1;
    wait_n(4);
    check("R3 insert prompt still held", 16'hAAAA);
    wait_n(12);
    check("R2 remove prompt shown", 16'hBBBB);
    wait_n(30);
    check("R4 remove waits for release", 16'hBBBB);
    btn_ticket = 1'b0;
    wait_n(6);
    check("R5 payment starts at fee", 16'hF150);
  endtask

  task automatic t_remove_hold();
    do_reset();
    press(4'b0001, 2);
    wait_n(6);
    check("R3 remove prompt held after early release", 16'hBBBB);
    wait_n(15);
    check("R2 payment after remove prompt", 16'hF150);
  endtask

  task automatic t_coins();
    go_to_pay();
    press(4'b1000, 20);
    check("R6 long fifty counted once", 16'hF100);
    press(4'b0100, 3);
    check("R6 twenty", 16'hF080);
    press(4'b0010, 3);
    check("R6 ten", 16'hF070);
    press(4'b1000, 3);
    check("R6 fifty", 16'hF020);
    press(4'b1000, 3);
    check("R8 overpay clamps to zero", 16'hF000);
    wait_n(15);
    check("R8 paid returns to insert", 16'hAAAA);
    press(4'b0100, 3);
    check("R9 coin in insert after paid", 16'hAAAA);
  endtask

  task automatic t_priority();
    go_to_pay();
    press(4'b1010, 3);
    check("R7 fifty beats ten", 16'hF100);
    press(4'b0110, 3);
    check("R7 twenty beats ten", 16'hF080);
  endtask

  task automatic t_exact();
    go_to_pay();
    press(4'b1000, 3);
    press(4'b1000, 3);
    press(4'b1000, 3);
    check("R8 exact payment shows zero", 16'hF000);
    wait_n(15);
    check("R2 cycle back to insert", 16'hAAAA);
  endtask

  task automatic t_reset_mid();
    go_to_pay();
    press(4'b0100, 3);
    do_reset();
    check("R1 reset during payment", 16'hAAAA);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_ignore_coins();
    t_prompt_hold();
    t_remove_hold();
    t_coins();
    t_priority();
    t_exact();
    t_reset_mid();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    report();
  end
endmodule